// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the word address for a synchronous burst memory. When either of two independent active-low load strobes is sampled low at a rising clock edge, it captures a full external address. That address becomes the first address of a four-word burst. The next addresses come from an internal step counter that clears on each load. Only the two lowest address bits take part in the sequence. The upper bits stay at the loaded value.

A mode input picks one of two orders. In linear order, the low bits count upward from the start offset and wrap modulo four. In interleaved order, the low bits are the start offset XORed with the step count. An active-low advance input moves the burst forward one position per edge. When the advance input is high, the burst is suspended and the same address repeats. The output is the stored start address combined with the step count, so it follows the mode level as soon as the mode changes.

Top module: `burst_addr_seq`

## Requirements
- R1: With `ilv_mode` low, each advance sets the low two bits of `addr_out` to (start offset + advances since load) modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R2: With `ilv_mode` high, the low two bits of `addr_out` equal the start offset XORed with the number of advances since load, modulo 4. For example, a start of 01 gives 01, 00, 11, 10, and a start of 11 gives 11, 10, 01, 00.
- R3: A low level on `ld_a_n` or on `ld_b_n` at a rising edge loads `addr_in`. From the next cycle, `addr_out` equals that value.
- R4: When both strobes are high and `step_n` is high at an edge, `addr_out` keeps its value, as long as the mode is unchanged.
- R5: After the fourth address, further advances wrap. The fifth address equals the loaded address, and the sequence repeats.
- R6: `addr_in` has no effect at edges where both strobes are high.
- R7: Bits `[AW-1:2]` of `addr_out` change only through a load. They are never altered by advances.
- R8: A synchronous active-low reset (`rst_n`) clears the stored address and the step counter, so `addr_out` reads zero.
- R9: A strobe that is low takes priority over `step_n`. A load in the same cycle as an advance gives the external address, not an advanced one.
- R10: `addr_out` reflects the level currently on `ilv_mode` without waiting for a clock edge. A mode change during a burst is applied to the current step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_a_n | input | 1 | First load strobe, active low |
| ld_b_n | input | 1 | Second load strobe, active low |
| step_n | input | 1 | Burst advance, active low; high suspends |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current burst address |

## Verification
The hardest case to reach from the ports is a wrap past the fourth address that is interleaved with suspended cycles, for every start offset in both orders. Reaching it requires a load, several advances and holds in a fixed order. The stimulus sweeps both modes, all four start offsets and both strobes. For each combination it loads, advances five times so the sequence wraps, and then suspends. During the same run it changes `addr_in` to unrelated values, so any unwanted sampling of the address shows up at the output. Further cases flip the mode mid-burst, assert a strobe together with an advance, and apply a mid-run reset.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_a_n,
  input  logic          ld_b_n,
  input  logic          step_n,
  input  logic          ilv_mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  localparam int LW = 2;

  logic [AW-1:0] base_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] low;
  logic          load;

  assign load = !ld_a_n || !ld_b_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (!step_n) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign low      = ilv_mode ? (base_q[LW-1:0] ^ cnt_q) : (base_q[LW-1:0] + cnt_q);
  assign addr_out = {base_q[AW-1:LW], low};

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_out == $past(addr_in));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> ($stable(addr_out) || (ilv_mode != $past(ilv_mode))));

  a_r7_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[AW-1:LW] == $past(addr_out[AW-1:LW]));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && cnt_q == 2'd3) |=> addr_out[LW-1:0] == base_q[LW-1:0]);

  a_r1_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && !ilv_mode) |=>
      (ilv_mode || addr_out[LW-1:0] == 2'($past(addr_out[LW-1:0]) + 2'd1)));

  a_r2_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_n && ilv_mode) |=>
      (!ilv_mode || (addr_out[LW-1:0] ^ base_q[LW-1:0]) ==
        2'(($past(addr_out[LW-1:0]) ^ $past(base_q[LW-1:0])) + 2'd1)));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_a_n;
  logic          ld_b_n;
  logic          step_n;
  logic          ilv_mode;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n),
    .step_n(step_n), .ilv_mode(ilv_mode), .addr_in(addr_in), .addr_out(addr_out)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, addr_out, exp);
    end
  endtask

  function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input int k);
    logic [1:0] kk;
    kk = 2'(k % 4);
    return m ? (s ^ kk) : 2'(s + kk);
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] start;
    rst_n = 1'b0; ld_a_n = 1'b1; ld_b_n = 1'b1; step_n = 1'b1;
    ilv_mode = 1'b0; addr_in = '0;
    tick(); tick();
    chk("R8 reset", '0);
    rst_n = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int src = 0; src < 2; src++) begin
          ilv_mode = 1'(m);
          start = {15'(m * 4099 + s * 311 + src * 77 + 1), 2'(s)};
          addr_in = start;
          if (src == 0) ld_a_n = 1'b0; else ld_b_n = 1'b0;
          step_n = 1'b1;
          tick();
          chk("R3 load", start);
          ld_a_n = 1'b1; ld_b_n = 1'b1;
          for (int k = 1; k <= 5; k++) begin
            addr_in = ~start ^ AW'(k * 13);
            step_n = 1'b0;
            tick();
            if (k >= 4) chk("R5 wrap", {start[AW-1:2], exp_low(1'(m), 2'(s), k)});
            else if (m == 0) chk("R1 linear", {start[AW-1:2], exp_low(1'b0, 2'(s), k)});
            else chk("R2 interleaved", {start[AW-1:2], exp_low(1'b1, 2'(s), k)});
          end
          step_n = 1'b1;
          addr_in = '1;
          tick();
          chk("R4 suspend", {start[AW-1:2], exp_low(1'(m), 2'(s), 5)});
          tick();
          chk("R6 addr ignored", {start[AW-1:2], exp_low(1'(m), 2'(s), 5)});
          chk("R7 upper bits", {start[AW-1:2], exp_low(1'(m), 2'(s), 5)});
          ilv_mode = ~ilv_mode;
          #1;
          chk("R10 mode change", {start[AW-1:2], exp_low(1'(1 - m), 2'(s), 5)});
          step_n = 1'b0;
          tick();
          chk("R10 mode after step", {start[AW-1:2], exp_low(1'(1 - m), 2'(s), 6)});
          step_n = 1'b1;
        end
      end
    end

    ilv_mode = 1'b0;
    start = 17'h1ABC2;
    addr_in = start; ld_b_n = 1'b0; step_n = 1'b0;
    tick();
    chk("R9 strobe priority", start);
    ld_b_n = 1'b1;
    tick();
    chk("R1 linear after priority load", {start[AW-1:2], 2'b11});

    rst_n = 1'b0; step_n = 1'b1;
    tick();
    chk("R8 mid-run reset", '0);
    rst_n = 1'b1;
    step_n = 1'b0;
    tick();
    chk("R8 counter cleared", 17'h00001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule